// File: doc/BRIEF.md
# Bit-Manipulation Count/Rotate ALU

`bmu_alu` is a purely combinational execution unit for a 64-bit core. An already decoded operation select, two 64-bit source values and a word-mode flag enter. A 64-bit result and an illegal flag leave in the same cycle. Operand `a_i` is the data input for every unary operation. Operand `b_i` supplies the second value for the logic and compare operations, and the bit index or rotate amount for the single-bit and rotate operations.

The operations are:
- leading-zero, trailing-zero and population counts;
- logic operations with an inverted second operand;
- signed and unsigned minimum and maximum;
- sign extension from byte or halfword, and zero extension from halfword;
- single-bit set, clear, invert and extract;
- rotation in either direction;
- a full byte swap;
- a per-byte OR-reduce that fills each byte.

The word-mode flag selects the 32-bit form of the counts, the rotates and the byte swap. Each 32-bit form returns its result sign- or zero-extended to 64 bits. An operation has a defined result for every input pattern, including an all-zero input to the counts.

Top module: `bmu_alu`

## Requirements
- R1: The operation codes on `op_i` are: 0 lead_zeros, 1 trail_zeros, 2 pop_count, 3 and_inv, 4 or_inv, 5 xor_inv, 6 min_s, 7 max_s, 8 min_u, 9 max_u, 10 sext_byte, 11 sext_half, 12 zext_half, 13 bit_set, 14 bit_clear, 15 bit_flip, 16 bit_get, 17 rot_left, 18 rot_right, 19 byte_swap, 20 byte_fill. Codes 21 to 31 are illegal. With `word_i`=1, every code other than 0, 1, 2, 17, 18 and 19 is illegal. An illegal code raises `illegal_o` and forces `result_o` to zero.
- R2: In full mode, lead_zeros and trail_zeros count the zero bits of `a_i` from bit 63 downward and from bit 0 upward. An all-zero operand gives 64.
- R3: In word mode, lead_zeros and trail_zeros look only at `a_i[31:0]`, counting from bit 31 downward and from bit 0 upward. An all-zero low word gives 32. Bits 63:32 have no effect.
- R4: pop_count returns the number of set bits of `a_i`, zero-extended. In word mode it counts only bits 31:0.
- R5: and_inv gives `a & ~b`, or_inv gives `a | ~b`, and xor_inv gives `~(a ^ b)`.
- R6: min_s and max_s compare as signed 64-bit values, and min_u and max_u compare as unsigned values. When the operands are equal, the result is `a_i`.
- R7: sext_byte copies bit 7 into bits 63:8. sext_half copies bit 15 into bits 63:16. zext_half clears bits 63:16.
- R8: For the single-bit operations the index is `b_i[5:0]`; bits 63:6 of `b_i` are ignored.
  - bit_set sets that bit of `a_i`, bit_clear clears it and bit_flip inverts it. All other bits of `a_i` pass through unchanged.
  - bit_get returns that bit of `a_i` in bit 0, with zeros above.
- R9: In full mode, rot_left and rot_right rotate `a_i` by `b_i[5:0]`; bits 63:6 of `b_i` are ignored.
- R10: In word mode, rot_left and rot_right rotate `a_i[31:0]` within 32 bits by `b_i[4:0]` and sign-extend bit 31 of the rotated word. All higher bits of both operands are ignored.
- R11: byte_swap reverses the order of all 8 bytes in full mode. In word mode it reverses the 4 low bytes and sign-extends the result from bit 31.
- R12: byte_fill makes each result byte 0xFF when the matching byte of `a_i` is nonzero, and 0x00 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code (see R1) |
| word_i | input | 1 | Selects the 32-bit form of the operation |
| a_i | input | 64 | First operand / data input |
| b_i | input | 64 | Second operand, bit index or rotate amount |
| result_o | output | 64 | Operation result |
| illegal_o | output | 1 | Operation code not valid in the current mode |

## Verification
Every result and the illegal flag are due in the same cycle as the inputs, with no register on the path. The bench applies each stimulus just after a rising clock edge and samples at the following falling edge, half a period later. It sweeps all 32 codes in both modes over a grid of corner operands:
- zero and all-ones words;
- single-bit words at bit 31 and bit 63;
- amounts of 0, 1, 31, 32 and 63, and amounts with set high bits that must be ignored.

Each case is compared against an arithmetic model written separately in the bench.

// File: rtl/bmu_pkg.sv
`timescale 1ns/1ps
package bmu_pkg;
  localparam int XLEN = 64;
  localparam int HALF = XLEN / 2;
  localparam int CW   = $clog2(XLEN + 1);
  localparam int SW   = $clog2(XLEN);
  localparam int OPW  = 5;

  typedef enum logic [OPW-1:0] {
    OP_LZ    = 5'd0,
    OP_TZ    = 5'd1,
    OP_POP   = 5'd2,
    OP_ANDN  = 5'd3,
    OP_ORN   = 5'd4,
    OP_XNOR  = 5'd5,
    OP_MIN   = 5'd6,
    OP_MAX   = 5'd7,
    OP_MINU  = 5'd8,
    OP_MAXU  = 5'd9,
    OP_SEXTB = 5'd10,
    OP_SEXTH = 5'd11,
    OP_ZEXTH = 5'd12,
    OP_BSET  = 5'd13,
    OP_BCLR  = 5'd14,
    OP_BINV  = 5'd15,
    OP_BGET  = 5'd16,
    OP_ROL   = 5'd17,
    OP_ROR   = 5'd18,
    OP_BSWAP = 5'd19,
    OP_BFILL = 5'd20
  } bmu_op_e;

  typedef enum logic [1:0] {
    BK_SET = 2'd0,
    BK_CLR = 2'd1,
    BK_INV = 2'd2,
    BK_GET = 2'd3
  } bit_kind_e;
endpackage

// File: rtl/bmu_count.sv
`timescale 1ns/1ps
module bmu_count #(
  parameter int XLEN = bmu_pkg::XLEN,
  parameter int CW   = $clog2(XLEN + 1)
) (
  input  logic [XLEN-1:0] src_i,
  input  logic            word_i,
  output logic [CW-1:0]   lz_o,
  output logic [CW-1:0]   tz_o,
  output logic [CW-1:0]   pop_o
);
  localparam int HALF = XLEN / 2;

  int lim;
  int lz_v;
  int tz_v;
  int pop_v;
  logic [XLEN-1:0] msk;

  always_comb begin
    lim   = word_i ? HALF : XLEN;
    msk   = word_i ? {{HALF{1'b0}}, src_i[HALF-1:0]} : src_i;
    lz_v  = lim;
    tz_v  = lim;
    pop_v = 0;
    // ascending scan: highest set bit writes last
    for (int i = 0; i < XLEN; i++)
      if (msk[i]) lz_v = lim - 1 - i;
    for (int i = XLEN - 1; i >= 0; i--)
      if (msk[i]) tz_v = i;
    for (int i = 0; i < XLEN; i++)
      pop_v = pop_v + int'(msk[i]);
    lz_o  = CW'(lz_v);
    tz_o  = CW'(tz_v);
    pop_o = CW'(pop_v);

    p_zero_width_r2: assert (msk != '0 || (lz_o == CW'(lim) && tz_o == CW'(lim)))
      else $error("zero operand count not width");
    p_count_sum_r4: assert (msk == '0 || (lz_v + tz_v + pop_v <= lim))
      else $error("count sum exceeds width");
  end
endmodule

// File: rtl/bmu_rotate.sv
`timescale 1ns/1ps
module bmu_rotate #(
  parameter int XLEN = bmu_pkg::XLEN,
  parameter int SW   = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] src_i,
  input  logic [SW-1:0]   amt_i,
  input  logic            left_i,
  input  logic            word_i,
  output logic [XLEN-1:0] res_o
);
  localparam int HALF = XLEN / 2;

  logic [2*XLEN-1:0] tf;
  logic [XLEN-1:0]   full_r;
  logic [HALF-1:0]   lo;
  logic [XLEN-1:0]   tw;
  logic [HALF-1:0]   word_r;

  always_comb begin
    tf     = left_i ? ({src_i, src_i} << amt_i) : ({src_i, src_i} >> amt_i);
    full_r = left_i ? tf[2*XLEN-1:XLEN] : tf[XLEN-1:0];
    lo     = src_i[HALF-1:0];
    tw     = left_i ? ({lo, lo} << amt_i[SW-2:0]) : ({lo, lo} >> amt_i[SW-2:0]);
    word_r = left_i ? tw[XLEN-1:HALF] : tw[HALF-1:0];
    res_o  = word_i ? {{HALF{word_r[HALF-1]}}, word_r} : full_r;

    p_rot_pop_r9: assert (word_i ? ($countones(word_r) == $countones(lo))
                                 : ($countones(full_r) == $countones(src_i)))
      else $error("rotate changed bit count");
    p_rot_zero_r10: assert (!(word_i && amt_i[SW-2:0] == '0) || word_r == lo)
      else $error("word rotate by zero changed data");
  end
endmodule

// File: rtl/bmu_bitop.sv
`timescale 1ns/1ps
module bmu_bitop
  import bmu_pkg::*;
#(
  parameter int XLEN = bmu_pkg::XLEN,
  parameter int SW   = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] src_i,
  input  logic [SW-1:0]   idx_i,
  input  bit_kind_e       kind_i,
  output logic [XLEN-1:0] res_o
);
  logic [XLEN-1:0] mask;

  always_comb begin
    mask = {{(XLEN-1){1'b0}}, 1'b1} << idx_i;
    case (kind_i)
      BK_SET:  res_o = src_i | mask;
      BK_CLR:  res_o = src_i & ~mask;
      BK_INV:  res_o = src_i ^ mask;
      default: res_o = {{(XLEN-1){1'b0}}, |(src_i & mask)};
    endcase

    p_bit_keep_r8: assert (kind_i == BK_GET || ((res_o ^ src_i) & ~mask) == '0)
      else $error("single-bit op touched other bits");
    p_bit_get_r8: assert (kind_i != BK_GET || res_o[XLEN-1:1] == '0)
      else $error("bit extract has high bits set");
  end
endmodule

// File: rtl/bmu_bytes.sv
`timescale 1ns/1ps
module bmu_bytes #(
  parameter int XLEN = bmu_pkg::XLEN
) (
  input  logic [XLEN-1:0] src_i,
  output logic [XLEN-1:0] swap_full_o,
  output logic [XLEN-1:0] swap_word_o,
  output logic [XLEN-1:0] fill_o
);
  localparam int NB   = XLEN / 8;
  localparam int HALF = XLEN / 2;

  logic [HALF-1:0] sw_lo;

  for (genvar g = 0; g < NB; g++) begin : g_byte
    assign fill_o[g*8 +: 8]      = {8{|src_i[g*8 +: 8]}};
    assign swap_full_o[g*8 +: 8] = src_i[(NB-1-g)*8 +: 8];
  end
  for (genvar g = 0; g < NB/2; g++) begin : g_wbyte
    assign sw_lo[g*8 +: 8] = src_i[(NB/2-1-g)*8 +: 8];
  end
  assign swap_word_o = {{HALF{sw_lo[HALF-1]}}, sw_lo};

  always_comb begin
    p_fill_zero_r12: assert ((fill_o == '0) == (src_i == '0))
      else $error("byte fill zero mismatch");
    p_swap_pop_r11: assert ($countones(swap_full_o) == $countones(src_i))
      else $error("byte swap changed bit count");
  end
endmodule

// File: rtl/bmu_alu.sv
`timescale 1ns/1ps
module bmu_alu
  import bmu_pkg::*;
(
  input  logic [OPW-1:0]  op_i,
  input  logic            word_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] result_o,
  output logic            illegal_o
);
  bmu_op_e         op;
  logic [CW-1:0]   lz, tz, pop;
  logic [XLEN-1:0] rot_res, bit_res, swap_f, swap_w, fill;
  bit_kind_e       kind;
  logic            rot_left;
  logic            op_ok, word_ok;
  logic [XLEN-1:0] res_raw;

  assign op       = bmu_op_e'(op_i);
  assign rot_left = (op == OP_ROL);

  always_comb begin
    case (op)
      OP_BSET: kind = BK_SET;
      OP_BCLR: kind = BK_CLR;
      OP_BINV: kind = BK_INV;
      default: kind = BK_GET;
    endcase
  end

  bmu_count #(.XLEN(XLEN), .CW(CW)) u_count (
    .src_i (a_i), .word_i (word_i), .lz_o (lz), .tz_o (tz), .pop_o (pop)
  );

  bmu_rotate #(.XLEN(XLEN), .SW(SW)) u_rotate (
    .src_i (a_i), .amt_i (b_i[SW-1:0]), .left_i (rot_left),
    .word_i (word_i), .res_o (rot_res)
  );

  bmu_bitop #(.XLEN(XLEN), .SW(SW)) u_bitop (
    .src_i (a_i), .idx_i (b_i[SW-1:0]), .kind_i (kind), .res_o (bit_res)
  );

  bmu_bytes #(.XLEN(XLEN)) u_bytes (
    .src_i (a_i), .swap_full_o (swap_f), .swap_word_o (swap_w), .fill_o (fill)
  );

  always_comb begin
    op_ok   = 1'b1;
    word_ok = 1'b0;
    res_raw = '0;
    case (op)
      OP_LZ:    begin res_raw = XLEN'(lz);  word_ok = 1'b1; end
      OP_TZ:    begin res_raw = XLEN'(tz);  word_ok = 1'b1; end
      OP_POP:   begin res_raw = XLEN'(pop); word_ok = 1'b1; end
      OP_ANDN:  res_raw = a_i & ~b_i;
      OP_ORN:   res_raw = a_i | ~b_i;
      OP_XNOR:  res_raw = ~(a_i ^ b_i);
      OP_MIN:   res_raw = ($signed(a_i) <= $signed(b_i)) ? a_i : b_i;
      OP_MAX:   res_raw = ($signed(a_i) >= $signed(b_i)) ? a_i : b_i;
      OP_MINU:  res_raw = (a_i <= b_i) ? a_i : b_i;
      OP_MAXU:  res_raw = (a_i >= b_i) ? a_i : b_i;
      OP_SEXTB: res_raw = {{(XLEN-8){a_i[7]}}, a_i[7:0]};
      OP_SEXTH: res_raw = {{(XLEN-16){a_i[15]}}, a_i[15:0]};
      OP_ZEXTH: res_raw = {{(XLEN-16){1'b0}}, a_i[15:0]};
      OP_BSET, OP_BCLR, OP_BINV, OP_BGET: res_raw = bit_res;
      OP_ROL, OP_ROR: begin res_raw = rot_res; word_ok = 1'b1; end
      OP_BSWAP: begin res_raw = word_i ? swap_w : swap_f; word_ok = 1'b1; end
      OP_BFILL: res_raw = fill;
      default:  op_ok = 1'b0;
    endcase
    illegal_o = !op_ok || (word_i && !word_ok);
    result_o  = illegal_o ? '0 : res_raw;

    p_illegal_zero_r1: assert (!illegal_o || result_o == '0)
      else $error("illegal op produced data");
    p_minmax_pick_r6: assert (illegal_o || !(op inside {OP_MIN, OP_MAX, OP_MINU, OP_MAXU})
                              || result_o == a_i || result_o == b_i)
      else $error("min/max result is neither operand");
    p_ext_upper_r7: assert (illegal_o || op != OP_ZEXTH || result_o[XLEN-1:16] == '0)
      else $error("zero extension left high bits");
  end
endmodule

// File: tb/bmu_alu_bench.sv
`timescale 1ns/1ps
module bmu_alu_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  op_i = '0;
  logic        word_i = 1'b0;
  logic [63:0] a_i = '0;
  logic [63:0] b_i = '0;
  logic [63:0] result_o;
  logic        illegal_o;

  int checks = 0;
  int errors = 0;
  logic [63:0] pats [12];

  always #5 clk = ~clk;

  bmu_alu u_bmu_alu (
    .op_i (op_i), .word_i (word_i), .a_i (a_i), .b_i (b_i),
    .result_o (result_o), .illegal_o (illegal_o)
  );

  function automatic string req_of(int op, bit w);
    if (op > 20) return "R1";
    if (w && !(op inside {0, 1, 2, 17, 18, 19})) return "R1";
    case (op)
      0, 1:    return w ? "R3" : "R2";
      2:       return "R4";
      3, 4, 5: return "R5";
      6, 7, 8, 9: return "R6";
      10, 11, 12: return "R7";
      13, 14, 15, 16: return "R8";
      17, 18:  return w ? "R10" : "R9";
      19:      return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic model(input int op, input bit w, input logic [63:0] a,
                       input logic [63:0] b, output logic [63:0] r, output bit ill);
    int width;
    int n;
    int amt;
    logic [63:0] x;
    logic [31:0] y;
    width = w ? 32 : 64;
    x = w ? {32'h0, a[31:0]} : a;
    ill = (op > 20) || (w && !(op inside {0, 1, 2, 17, 18, 19}));
    r = '0;
    case (op)
      0: begin n = 0; while (n < width && !x[width-1-n]) n++; r = 64'(n); end
      1: begin n = 0; while (n < width && !x[n]) n++; r = 64'(n); end
      2: begin n = 0; for (int k = 0; k < width; k++) if (x[k]) n++; r = 64'(n); end
      3: r = a & ~b;
      4: r = a | ~b;
      5: r = a ~^ b;
      6: r = (longint'(a) > longint'(b)) ? b : a;
      7: r = (longint'(a) < longint'(b)) ? b : a;
      8: r = (a > b) ? b : a;
      9: r = (a < b) ? b : a;
      10: r = (a[7]) ? (a | 64'hFFFF_FFFF_FFFF_FF00) : (a & 64'hFF);
      11: r = (a[15]) ? (a | 64'hFFFF_FFFF_FFFF_0000) : (a & 64'hFFFF);
      12: r = a & 64'hFFFF;
      13: r = a | (64'd1 << b[5:0]);
      14: r = a & ~(64'd1 << b[5:0]);
      15: r = a ^ (64'd1 << b[5:0]);
      16: r = (a >> b[5:0]) & 64'd1;
      17, 18: begin
        if (w) begin
          y = a[31:0]; amt = int'(b[4:0]);
          for (int k = 0; k < amt; k++)
            y = (op == 17) ? {y[30:0], y[31]} : {y[0], y[31:1]};
          r = {{32{y[31]}}, y};
        end else begin
          r = a; amt = int'(b[5:0]);
          for (int k = 0; k < amt; k++)
            r = (op == 17) ? {r[62:0], r[63]} : {r[0], r[63:1]};
        end
      end
      19: begin
        n = width / 8;
        for (int k = 0; k < n; k++) r[8*k +: 8] = a[8*(n-1-k) +: 8];
        if (w) r = {{32{r[31]}}, r[31:0]};
      end
      20: for (int k = 0; k < 8; k++) r[8*k +: 8] = (a[8*k +: 8] != 0) ? 8'hFF : 8'h00;
      default: r = '0;
    endcase
    if (ill) r = '0;
  endtask

  task automatic check(input int op, input bit w, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] er;
    bit ei;
    @(posedge clk);
    #1;
    op_i = 5'(op); word_i = w; a_i = a; b_i = b;
    model(op, w, a, b, er, ei);
    @(negedge clk);
    checks++;
    if (result_o !== er || illegal_o !== ei) begin
      errors++;
      $display("FAIL %s op=%0d w=%0d a=%h b=%h: got %h/%0b expected %h/%0b",
               req_of(op, w), op, w, a, b, result_o, illegal_o, er, ei);
    end
  endtask

  initial begin
    pats[0]  = 64'h0;
    pats[1]  = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[2]  = 64'h1;
    pats[3]  = 64'h8000_0000_0000_0000;
    pats[4]  = 64'h0000_0000_8000_0000;
    pats[5]  = 64'hFFFF_FFFF_0000_0000;
    pats[6]  = 64'h0000_0000_0000_0080;
    pats[7]  = 64'h0123_4567_89AB_CDEF;
    pats[8]  = 64'h00FF_0000_0000_8000;
    pats[9]  = 64'h0000_0000_0000_003F;
    pats[10] = 64'hFFFF_FFFF_FFFF_FFE0;
    pats[11] = 64'h7FFF_FFFF_FFFF_FFDF;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // reset state: all-zero inputs select a count of zero -> width (R2)
    @(negedge clk);
    checks++;
    if (result_o !== 64'd64 || illegal_o !== 1'b0) begin
      errors++;
      $display("FAIL R2 reset state: got %h/%0b expected %h/0", result_o, illegal_o, 64'd64);
    end
    for (int op = 0; op < 32; op++)
      for (int w = 0; w < 2; w++)
        for (int i = 0; i < 12; i++)
          for (int j = 0; j < 12; j++)
            check(op, w[0], pats[i], pats[j]);
    // R3: upper word bits ignored by word-mode counts
    check(0, 1'b1, 64'hFFFF_FFFF_0000_0001, 64'h0);
    check(1, 1'b1, 64'hFFFF_FFFF_0000_0000, 64'h0);
    // R10: high amount bits ignored in word rotate
    check(17, 1'b1, 64'hABCD_0000_8000_0001, 64'hFFFF_FFFF_FFFF_FFE1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule